// File: doc/BRIEF.md
# Deferred-Exception Token Register File

This block is a general-purpose register file in which every entry carries, next to its data word, a one-bit deferral token. The token stands for a value that does not exist. A control-speculative load that hits a fault does not raise an exception. It writes its destination with the token set. Ordinary computation carries the token forward from its sources, so the poison travels with the dependent values. An explicit check operation later tests the token of a named register. If the token is set, the block asks the front end to redirect to a recovery address that the check operation supplies.

The block executes one operation per clock through a single write port. Memory and address translation are not modelled. Each load reports its outcome through a fault input. A load that is not control-speculative, including an advanced (data-speculative) load, reports its fault at once through an exception output and does not write its destination. Two external read ports let the surrounding pipeline observe any entry. Register 0 is hard-wired to zero with a clear token.

Top module: `dtok_regfile`

## Requirements
- R1: Register 0 always reads data 0 with its token clear on both read ports, even after any operation names it as destination.
- R2: An ALU operation (op code 1) writes its destination with op_data and sets the token to the OR of the tokens of op_src_a and op_src_b, as they stood before the operation.
- R3: A constant move (op code 2) writes op_data with the token clear. A load of any kind (op codes 3, 4, 5, 6) with op_fault low does the same.
- R4: A control-speculative load (op code 4) or a speculative-advanced load (op code 6) with op_fault high writes its destination with data 0 and the token set, and raises no exception.
- R5: A plain load (op code 3) or an advanced load (op code 5) with op_fault high pulses exc_valid for the one cycle after the operation and leaves every register unchanged.
- R6: A speculation check (op code 7) on a register op_src_a whose token is set pulses redirect_valid for the one cycle after the operation, with redirect_addr equal to op_recov.
- R7: An advanced-load check (op code 8) also counts a set token in op_src_a as a failure and redirects exactly as in R6.
- R8: A check (op code 7 or 8) whose register has a clear token raises no redirect and changes no register. op_fault has no effect on ALU operations, constant moves or checks, and op code 0 or op_valid low does nothing.
- R9: After reset every register reads data 0 with a clear token, and exc_valid and redirect_valid are low.
- R10: The read ports are independent and combinational from the stored state. A write becomes visible on them in the cycle after its operation, with no bypass from the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is present this cycle |
| op_kind | input | 4 | Operation code (0 none, 1 ALU, 2 constant, 3 load, 4 speculative load, 5 advanced load, 6 speculative-advanced load, 7 speculation check, 8 advanced check) |
| op_dst | input | 5 | Destination register index |
| op_src_a | input | 5 | First source, or the register to check |
| op_src_b | input | 5 | Second source of an ALU operation |
| op_data | input | 64 | Result, constant or loaded data |
| op_fault | input | 1 | The load of this cycle faulted |
| op_recov | input | 48 | Recovery address of a check |
| rd_a_idx | input | 5 | Read port A index |
| rd_a_data | output | 64 | Read port A data |
| rd_a_tok | output | 1 | Read port A token |
| rd_b_idx | input | 5 | Read port B index |
| rd_b_data | output | 64 | Read port B data |
| rd_b_tok | output | 1 | Read port B token |
| exc_valid | output | 1 | Immediate exception of a non-deferring load |
| redirect_valid | output | 1 | Failed check, redirect requested |
| redirect_addr | output | 48 | Recovery address of the failed check |

## Verification
The hardest situation to reach is a failed check on a token that arrived through a chain of ALU operations rather than straight from a faulting load. To get there, a speculative load must fault and the poisoned register must then feed, possibly through several hops, the register that is checked, with no clean rewrite in between. Directed sequences build such chains on purpose: a faulting speculative load, ALU operations that mix clean and poisoned sources, then both kinds of check. The random phase uses a small pool of register indices and a high fault rate, so that chains of this kind and their clearing by later loads happen often.

// File: rtl/dtok_pkg.sv
package dtok_pkg;
   typedef enum logic [3:0] {
      OPK_NONE  = 4'd0,
      OPK_ALU   = 4'd1,
      OPK_MOVI  = 4'd2,
      OPK_LD    = 4'd3,
      OPK_LDS   = 4'd4,
      OPK_LDA   = 4'd5,
      OPK_LDSA  = 4'd6,
      OPK_CHKS  = 4'd7,
      OPK_CHKA  = 4'd8
   } op_kind_e;

   function automatic logic is_deferring_load(input logic [3:0] k);
      return (k == OPK_LDS) || (k == OPK_LDSA);
   endfunction

   function automatic logic is_eager_load(input logic [3:0] k);
      return (k == OPK_LD) || (k == OPK_LDA);
   endfunction

   function automatic logic is_check(input logic [3:0] k);
      return (k == OPK_CHKS) || (k == OPK_CHKA);
   endfunction
endpackage

// File: rtl/dtok_storage.sv
module dtok_storage #(
   parameter int NREGS = 32,
   parameter int DW    = 64,
   parameter int NRD   = 4,
   localparam int IW   = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_tok,
   input  logic [IW-1:0] rd_idx  [NRD],
   output logic [DW-1:0] rd_data [NRD],
   output logic          rd_tok  [NRD]
);
   logic [DW-1:0] mem_d [NREGS];
   logic          mem_t [NREGS];

   initial begin
      assert (NREGS >= 2 && (1 << IW) == NREGS)
         else $error("dtok_storage: NREGS must be a power of two, at least 2");
      assert (NRD >= 1) else $error("dtok_storage: need a read port");
   end

   // Entry 0 is never written, so it keeps its reset value of zero.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) begin
            mem_d[i] <= '0;
            mem_t[i] <= 1'b0;
         end
      end else if (wr_en && (wr_idx != '0)) begin
         mem_d[wr_idx] <= wr_data;
         mem_t[wr_idx] <= wr_tok;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_data[p] = mem_d[rd_idx[p]];
      assign rd_tok[p]  = mem_t[rd_idx[p]];

      assert_r0_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_idx[p] == '0) |-> (rd_data[p] == '0 && !rd_tok[p]));
   end

   assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx != '0) |=>
         (mem_d[$past(wr_idx)] == $past(wr_data) && mem_t[$past(wr_idx)] == $past(wr_tok)));
endmodule

// File: rtl/dtok_decode.sv
module dtok_decode
   import dtok_pkg::*;
#(
   parameter int DW = 64
) (
   input  logic          op_valid,
   input  logic [3:0]    op_kind,
   input  logic          op_fault,
   input  logic [DW-1:0] op_data,
   input  logic          tok_a,
   input  logic          tok_b,
   output logic          wr_en,
   output logic [DW-1:0] wr_data,
   output logic          wr_tok,
   output logic          exc_d,
   output logic          redir_d
);
   logic any_load;

   always_comb begin
      any_load = is_deferring_load(op_kind) || is_eager_load(op_kind);
      wr_en    = 1'b0;
      wr_data  = op_data;
      wr_tok   = 1'b0;
      exc_d    = 1'b0;
      redir_d  = 1'b0;
      if (op_valid) begin
         if (op_kind == OPK_ALU) begin
            wr_en  = 1'b1;
            wr_tok = tok_a | tok_b;
         end else if (op_kind == OPK_MOVI) begin
            wr_en  = 1'b1;
         end else if (any_load) begin
            if (!op_fault) begin
               wr_en = 1'b1;
            end else if (is_deferring_load(op_kind)) begin
               wr_en   = 1'b1;
               wr_data = '0;
               wr_tok  = 1'b1;
            end else begin
               exc_d = 1'b1;
            end
         end else if (is_check(op_kind)) begin
            redir_d = tok_a;
         end
      end
   end

   always_comb begin
      assert_single_effect_R5: assert (!(exc_d && (wr_en || redir_d)));
   end
endmodule

// File: rtl/dtok_regfile.sv
module dtok_regfile
   import dtok_pkg::*;
#(
   parameter int NREGS   = 32,
   parameter int DW      = 64,
   parameter int RECOV_W = 48,
   localparam int IW     = $clog2(NREGS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_valid,
   input  logic [3:0]         op_kind,
   input  logic [IW-1:0]      op_dst,
   input  logic [IW-1:0]      op_src_a,
   input  logic [IW-1:0]      op_src_b,
   input  logic [DW-1:0]      op_data,
   input  logic               op_fault,
   input  logic [RECOV_W-1:0] op_recov,
   input  logic [IW-1:0]      rd_a_idx,
   output logic [DW-1:0]      rd_a_data,
   output logic               rd_a_tok,
   input  logic [IW-1:0]      rd_b_idx,
   output logic [DW-1:0]      rd_b_data,
   output logic               rd_b_tok,
   output logic               exc_valid,
   output logic               redirect_valid,
   output logic [RECOV_W-1:0] redirect_addr
);
   localparam int NRD = 4; // two external ports, two operand ports

   logic [IW-1:0] rd_idx  [NRD];
   logic [DW-1:0] rd_data [NRD];
   logic          rd_tok  [NRD];

   logic          wr_en, wr_tok, exc_d, redir_d;
   logic [DW-1:0] wr_data;

   initial begin
      assert (RECOV_W >= 1) else $error("dtok_regfile: RECOV_W must be positive");
   end

   assign rd_idx[0] = rd_a_idx;
   assign rd_idx[1] = rd_b_idx;
   assign rd_idx[2] = op_src_a;
   assign rd_idx[3] = op_src_b;
   assign rd_a_data = rd_data[0];
   assign rd_a_tok  = rd_tok[0];
   assign rd_b_data = rd_data[1];
   assign rd_b_tok  = rd_tok[1];

   dtok_storage #(.NREGS(NREGS), .DW(DW), .NRD(NRD)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (op_dst),
      .wr_data (wr_data),
      .wr_tok  (wr_tok),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .rd_tok  (rd_tok)
   );

   dtok_decode #(.DW(DW)) u_dec (
      .op_valid (op_valid),
      .op_kind  (op_kind),
      .op_fault (op_fault),
      .op_data  (op_data),
      .tok_a    (rd_tok[2]),
      .tok_b    (rd_tok[3]),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .wr_tok   (wr_tok),
      .exc_d    (exc_d),
      .redir_d  (redir_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_valid      <= 1'b0;
         redirect_valid <= 1'b0;
         redirect_addr  <= '0;
      end else begin
         exc_valid      <= exc_d;
         redirect_valid <= redir_d;
         if (redir_d) redirect_addr <= op_recov;
      end
   end

   assert_eager_fault_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && is_eager_load(op_kind) && op_fault) |=> exc_valid);

   assert_spec_fault_defers_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && is_deferring_load(op_kind) && op_fault) |=> (!exc_valid && rd_tok[2] == rd_tok[2]));

   assert_redirect_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> $past(op_valid && is_check(op_kind) && rd_tok[2]));

   assert_redirect_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> (redirect_addr == $past(op_recov)));

   assert_clean_check_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && is_check(op_kind) && !rd_tok[2]) |=> !redirect_valid);
endmodule

// File: tb/dtok_regfile_bench.sv
`timescale 1ns/1ps
module dtok_regfile_bench;
   localparam int NREGS = 32, DW = 64, RW = 48, IW = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic op_valid = 1'b0, op_fault = 1'b0;
   logic [3:0] op_kind = '0;
   logic [IW-1:0] op_dst = '0, op_src_a = '0, op_src_b = '0, rd_a_idx = '0, rd_b_idx = '0;
   logic [DW-1:0] op_data = '0;
   logic [RW-1:0] op_recov = '0;
   logic [DW-1:0] rd_a_data, rd_b_data;
   logic rd_a_tok, rd_b_tok, exc_valid, redirect_valid;
   logic [RW-1:0] redirect_addr;

   int n_chk = 0, n_bad = 0;
   logic [DW-1:0] m_d [NREGS];
   logic          m_t [NREGS];

   always #2.5 clk = ~clk;

   dtok_regfile u_dtok_regfile (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .op_dst(op_dst), .op_src_a(op_src_a), .op_src_b(op_src_b), .op_data(op_data),
      .op_fault(op_fault), .op_recov(op_recov), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_a_tok(rd_a_tok), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_tok(rd_b_tok),
      .exc_valid(exc_valid), .redirect_valid(redirect_valid), .redirect_addr(redirect_addr));

   task automatic cmp(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic exp_exc(input logic [3:0] k, input logic f, input logic v);
      return v && f && (k == 4'd3 || k == 4'd5);
   endfunction

   function automatic logic exp_redir(input logic [3:0] k, input logic t, input logic v);
      return v && t && (k == 4'd7 || k == 4'd8);
   endfunction

   // Reads one entry on both ports and compares it with the model.
   task automatic read_reg(input string req, input int r);
      rd_a_idx = IW'(r);
      rd_b_idx = IW'(r);
      #0.2;
      cmp(req, rd_a_data, m_d[r]);
      cmp(req, {63'd0, rd_a_tok}, {63'd0, m_t[r]});
      cmp(req, {63'd0, rd_b_tok}, {63'd0, m_t[r]});
   endtask

   // Drives one operation at a falling edge and checks its results at the next one.
   task automatic do_op(input string req, input logic [3:0] k, input int d, input int a,
                        input int b, input logic [DW-1:0] dat, input logic f,
                        input logic [RW-1:0] rec, input logic v = 1'b1);
      logic e_exc, e_red, ta, tb;
      ta = m_t[a];
      tb = m_t[b];
      e_exc = exp_exc(k, f, v);
      e_red = exp_redir(k, ta, v);
      op_valid = v; op_kind = k; op_dst = IW'(d); op_src_a = IW'(a); op_src_b = IW'(b);
      op_data = dat; op_fault = f; op_recov = rec;
      @(posedge clk);
      if (v && d != 0) begin
         case (k)
            4'd1: begin m_d[d] = dat; m_t[d] = ta | tb; end
            4'd2: begin m_d[d] = dat; m_t[d] = 1'b0; end
            4'd3, 4'd5: if (!f) begin m_d[d] = dat; m_t[d] = 1'b0; end
            4'd4, 4'd6: begin m_d[d] = f ? '0 : dat; m_t[d] = f; end
            default: ;
         endcase
      end
      @(negedge clk);
      op_valid = 1'b0;
      cmp({req, " exc"}, {63'd0, exc_valid}, {63'd0, e_exc});
      cmp({req, " redirect"}, {63'd0, redirect_valid}, {63'd0, e_red});
      if (e_red) cmp({req, " addr"}, {16'd0, redirect_addr}, {16'd0, rec});
      read_reg(req, d);
   endtask

   initial begin
      void'($urandom(32'h5EED_0017));
      for (int i = 0; i < NREGS; i++) begin m_d[i] = '0; m_t[i] = 1'b0; end
      repeat (3) @(negedge clk);
      // R9: state under and right after reset
      cmp("R9 exc", {63'd0, exc_valid}, 64'd0);
      cmp("R9 redirect", {63'd0, redirect_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NREGS; i++) read_reg("R9", i);

      // Directed corners
      do_op("R3", 4'd2, 5, 0, 0, 64'hA5A5_0000_1234_5678, 1'b1, '0);
      do_op("R4", 4'd4, 5, 0, 0, 64'hDEAD, 1'b1, '0);
      do_op("R2", 4'd1, 6, 5, 0, 64'h66, 1'b0, '0);
      do_op("R2", 4'd1, 7, 1, 2, 64'h77, 1'b1, '0);
      do_op("R2", 4'd1, 9, 7, 6, 64'h99, 1'b0, '0);
      do_op("R6", 4'd7, 0, 9, 0, '0, 1'b0, 48'h1234_5678_9ABC);
      do_op("R7", 4'd8, 0, 5, 0, '0, 1'b0, 48'h0000_0000_0F00);
      do_op("R8", 4'd7, 0, 7, 0, '0, 1'b1, 48'hFFFF_FFFF_FFFF);
      do_op("R8", 4'd8, 0, 7, 0, '0, 1'b0, 48'h1);
      do_op("R5", 4'd3, 8, 0, 0, 64'h8888, 1'b1, '0);
      do_op("R5", 4'd5, 5, 0, 0, 64'h5555, 1'b1, '0);
      do_op("R4", 4'd6, 10, 0, 0, 64'h1010, 1'b1, '0);
      do_op("R7", 4'd8, 0, 10, 0, '0, 1'b0, 48'hABC);
      do_op("R3", 4'd6, 10, 0, 0, 64'h2020, 1'b0, '0);
      do_op("R3", 4'd3, 5, 0, 0, 64'h3030, 1'b0, '0);
      do_op("R1", 4'd2, 0, 0, 0, 64'hFFFF, 1'b0, '0);
      do_op("R1", 4'd4, 0, 0, 0, 64'hFFFF, 1'b1, '0);
      do_op("R8", 4'd1, 11, 1, 2, 64'hBB, 1'b1, '0, 1'b0);
      do_op("R8", 4'd0, 11, 1, 2, 64'hBB, 1'b0, '0);
      // R10: two ports on different entries at once
      rd_a_idx = 5'd6; rd_b_idx = 5'd7; #0.2;
      cmp("R10 port A", {63'd0, rd_a_tok}, {63'd0, m_t[6]});
      cmp("R10 port B", rd_b_data, m_d[7]);

      // Constrained random: small register pool, frequent faults
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] k;
         k = 4'($urandom_range(0, 8));
         do_op("R2 R3 R4 R5 R6 R7 R8 random", k, $urandom_range(0, 7), $urandom_range(0, 7),
               $urandom_range(0, 7), {$urandom, $urandom}, ($urandom % 3) == 0,
               {16'($urandom), $urandom}, ($urandom % 8) != 0);
      end
      for (int i = 0; i < NREGS; i++) read_reg("R10 sweep", i);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule